// File: doc/BRIEF.md
# USB Endpoint Interrupt Generator

This block turns transaction-completion reports from a USB serial interface engine into interrupt requests, one for each of five endpoints. The engine reports each finished transaction on a small event port. The port carries a strobe that marks the last packet of a transaction, the endpoint index, the transfer direction and the handshake seen at the close. An interrupt is raised only when the closing handshake is the right one for the direction. For an IN transfer that is the ACK received from the host. For an OUT transfer that is the ACK the device sent back after the host wrote into the endpoint FIFO. An IN transfer that ends without an ACK raises nothing.

Each endpoint owns a two-state slot machine. `SLOT_IDLE` moves to `SLOT_PEND` on a qualified event for that endpoint (transition *raise*). `SLOT_PEND` stays in place while no acknowledge arrives (*hold*), and also when an acknowledge and a new event arrive in the same cycle (*re-raise*). `SLOT_PEND` returns to `SLOT_IDLE` on a firmware acknowledge with no new event (*retire*). The pending bits leave the block directly. A combined request is the OR of the pending bits, each gated by its enable. The enable masks only the combined request and never touches the pending state.

Top module: `usb_ep_irq_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no event, all `pend` bits and `irq_req` are 0.
- R2: When `txn_done`=1, `txn_dir`=1 (IN) and `txn_hs`=2'b01 (ACK received from host), with `txn_ep` in 0..4, `pend[txn_ep]` is 1 after the next rising clock edge.
- R3: When `txn_done`=1, `txn_dir`=0 (OUT) and `txn_hs`=2'b10 (ACK sent by the device), with `txn_ep` in 0..4, `pend[txn_ep]` is 1 after the next rising clock edge.
- R4: An IN event with `txn_hs`=2'b00 (no handshake) changes no `pend` bit. A handshake that does not match the direction also changes no `pend` bit: IN with 2'b10, OUT with 2'b01, or either direction with 2'b11.
- R5: With `txn_done`=0 (not the last packet), `txn_ep`, `txn_dir` and `txn_hs` change no `pend` bit.
- R6: An event whose `txn_ep` is 5, 6 or 7 changes no `pend` bit.
- R7: A set `pend[i]` stays 1 until `ack_clr[i]` is 1 at a rising edge. After that edge it is 0 when no new event for endpoint i is present.
- R8: If a qualified event for endpoint i and `ack_clr[i]` come in the same cycle, `pend[i]` is 1 after that edge.
- R9: `irq_req` is 1 exactly when some bit of `pend & irq_en` is 1. `irq_en` does not change `pend`.
- R10: `ack_clr[i]` has no effect on any other endpoint's bit, and has no effect on a bit that is already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_done | input | 1 | Strobe marking the last packet of a transaction |
| txn_ep | input | 3 | Endpoint index of the reported transaction |
| txn_dir | input | 1 | Direction: 1 = IN (to host), 0 = OUT (from host) |
| txn_hs | input | 2 | Closing handshake: 00 none, 01 ACK from host, 10 ACK by device, 11 other |
| ack_clr | input | 5 | Per-endpoint acknowledge from firmware, one cycle |
| irq_en | input | 5 | Per-endpoint enable for the combined request |
| pend | output | 5 | Per-endpoint pending interrupt bits |
| irq_req | output | 1 | Combined request: OR of enabled pending bits |

## Verification
A new completion event and a firmware acknowledge can arrive in the same cycle, either for the same endpoint or for different ones. The bench causes the same-endpoint case by driving `txn_done` with a qualifying handshake and the matching `ack_clr` bit in the same cycle. The bit must still read 1 after that edge. The cross-endpoint case drives the event for one endpoint while the acknowledge retires another. There the first bit must rise and the second must fall, and no other bit may move.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

    typedef enum logic [1:0] {
        HS_NONE   = 2'b00,
        HS_ACK_RX = 2'b01,
        HS_ACK_TX = 2'b10,
        HS_OTHER  = 2'b11
    } hs_code_t;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } txn_dir_t;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_t;

endpackage

// File: rtl/ep_evt_qualify.sv
module ep_evt_qualify
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 5,
    parameter int IDX_W  = 3
) (
    input  logic              txn_done,
    input  logic [IDX_W-1:0]  txn_ep,
    input  logic              txn_dir,
    input  logic [1:0]        txn_hs,
    output logic [NUM_EP-1:0] hit
);

    logic closing_ok;
    logic index_ok;

    // The right closing handshake depends on which side acknowledged
    always_comb begin
        unique case (txn_dir_t'(txn_dir))
            DIR_IN:  closing_ok = (hs_code_t'(txn_hs) == HS_ACK_RX);
            DIR_OUT: closing_ok = (hs_code_t'(txn_hs) == HS_ACK_TX);
            default: closing_ok = 1'b0;
        endcase
    end

    assign index_ok = (int'(txn_ep) < NUM_EP);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_dec
        assign hit[e] = txn_done && closing_ok && index_ok && (int'(txn_ep) == e);
    end

endmodule

// File: rtl/ep_pend_slot.sv
module ep_pend_slot
    import ep_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic retire,
    output logic pending
);

    slot_state_t state_q;
    slot_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // Next state: a raise in the same cycle as a retire wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (raise)              state_d = SLOT_PEND;
            SLOT_PEND: if (retire && !raise)   state_d = SLOT_IDLE;
            default:                           state_d = SLOT_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_PEND: pending = 1'b1;
            default:   pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/ep_req_combine.sv
module ep_req_combine #(
    parameter int NUM_EP = 5
) (
    input  logic [NUM_EP-1:0] pend,
    input  logic [NUM_EP-1:0] en,
    output logic              req
);

    assign req = |(pend & en);

endmodule

// File: rtl/usb_ep_irq_gen.sv
module usb_ep_irq_gen #(
    parameter int NUM_EP = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_done,
    input  logic [IDX_W-1:0]  txn_ep,
    input  logic              txn_dir,
    input  logic [1:0]        txn_hs,
    input  logic [NUM_EP-1:0] ack_clr,
    input  logic [NUM_EP-1:0] irq_en,
    output logic [NUM_EP-1:0] pend,
    output logic              irq_req
);

    logic [NUM_EP-1:0] hit;

    ep_evt_qualify #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_qual (
        .txn_done (txn_done),
        .txn_ep   (txn_ep),
        .txn_dir  (txn_dir),
        .txn_hs   (txn_hs),
        .hit      (hit)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_slot
        ep_pend_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise   (hit[e]),
            .retire  (ack_clr[e]),
            .pending (pend[e])
        );
    end

    ep_req_combine #(.NUM_EP(NUM_EP)) u_comb (
        .pend (pend),
        .en   (irq_en),
        .req  (irq_req)
    );

endmodule

// File: rtl/ep_irq_checker.sv
module ep_irq_checker #(
    parameter int NUM_EP = 5,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_done,
    input logic [IDX_W-1:0]  txn_ep,
    input logic              txn_dir,
    input logic [1:0]        txn_hs,
    input logic [NUM_EP-1:0] ack_clr,
    input logic [NUM_EP-1:0] irq_en,
    input logic [NUM_EP-1:0] pend,
    input logic              irq_req
);

    // R1: a cycle spent in reset leaves nothing pending
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (pend == '0));

    // R4: IN without handshake leaves all bits alone
    a_r4_in_noack: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_dir && txn_hs == 2'b00 && ack_clr == '0) |=> $stable(pend));

    // R5: no last-packet strobe, no change
    a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_done && ack_clr == '0) |=> $stable(pend));

    // R6: out-of-range index is ignored
    a_r6_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && int'(txn_ep) >= NUM_EP && ack_clr == '0) |=> $stable(pend));

    // R9: the combined request needs an enabled pending bit
    a_r9_req_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend & irq_en) != '0));

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        // R2: IN closed by host ACK sets the bit (also R8 when cleared together)
        a_r2_in_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (txn_done && txn_dir && txn_hs == 2'b01 && int'(txn_ep) == e) |=> pend[e]);

        // R3: OUT closed by device ACK sets the bit
        a_r3_out_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (txn_done && !txn_dir && txn_hs == 2'b10 && int'(txn_ep) == e) |=> pend[e]);

        // R7: a pending bit holds without its acknowledge (R10 for other bits)
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[e] && !ack_clr[e]) |=> pend[e]);
    end

endmodule

bind usb_ep_irq_gen ep_irq_checker #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_usb_ep_irq_gen.sv
module test_usb_ep_irq_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NEP        = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           txn_done = 1'b0;
    logic [2:0]     txn_ep = '0;
    logic           txn_dir = 1'b0;
    logic [1:0]     txn_hs = '0;
    logic [NEP-1:0] ack_clr = '0;
    logic [NEP-1:0] irq_en = '0;
    logic [NEP-1:0] pend;
    logic           irq_req;

    int n_checks = 0;
    int n_fails  = 0;
    logic [NEP-1:0] exp_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ep_irq_gen i_usb_ep_irq_gen (
        .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_ep(txn_ep),
        .txn_dir(txn_dir), .txn_hs(txn_hs), .ack_clr(ack_clr),
        .irq_en(irq_en), .pend(pend), .irq_req(irq_req)
    );

    task automatic check_vec(input string req, input logic [NEP-1:0] act, input logic [NEP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Model from the requirements: IN needs 01, OUT needs 10, index < 5, strobe high.
    function automatic logic [NEP-1:0] model_hit(input logic done, input int ep,
                                                 input logic dir, input logic [1:0] hs);
        logic [NEP-1:0] h = '0;
        if (done && ep < NEP && ((dir && hs == 2'b01) || (!dir && hs == 2'b10)))
            h[ep] = 1'b1;
        return h;
    endfunction

    // One cycle of stimulus; inputs change after the falling edge, results read 1 after the rising edge.
    task automatic step(input logic done, input int ep, input logic dir,
                        input logic [1:0] hs, input logic [NEP-1:0] clr);
        logic [NEP-1:0] h;
        @(negedge clk);
        txn_done = done; txn_ep = 3'(ep); txn_dir = dir; txn_hs = hs; ack_clr = clr;
        h = model_hit(done, ep, dir, hs);
        @(posedge clk);
        #1;
        exp_pend = (exp_pend & ~clr) | h;
        txn_done = 1'b0; txn_ep = '0; txn_dir = 1'b0; txn_hs = '0; ack_clr = '0;
    endtask

    task automatic clear_all();
        step(1'b0, 0, 1'b0, 2'b00, '1);
    endtask

    task automatic t_reset();
        check_vec("R1 pend in reset", pend, '0);
        check_bit("R1 irq_req in reset", irq_req, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 pend after release", pend, '0);
    endtask

    task automatic t_in_ack();
        for (int e = 0; e < NEP; e++) begin
            step(1'b1, e, 1'b1, 2'b01, '0);
            check_vec("R2 IN host ACK sets bit", pend, exp_pend);
        end
        check_vec("R2 all set", pend, 5'b11111);
        clear_all();
    endtask

    task automatic t_out_ack();
        step(1'b1, 2, 1'b0, 2'b10, '0);
        check_vec("R3 OUT device ACK ep2", pend, 5'b00100);
        step(1'b1, 4, 1'b0, 2'b10, '0);
        check_vec("R3 OUT device ACK ep4", pend, 5'b10100);
        clear_all();
    endtask

    task automatic t_no_ack();
        step(1'b1, 1, 1'b1, 2'b00, '0);
        check_vec("R4 IN without ACK", pend, 5'b00000);
        step(1'b1, 1, 1'b1, 2'b10, '0);
        check_vec("R4 IN with device-side code", pend, 5'b00000);
        step(1'b1, 3, 1'b0, 2'b01, '0);
        check_vec("R4 OUT with host-side code", pend, 5'b00000);
        step(1'b1, 0, 1'b0, 2'b11, '0);
        check_vec("R4 OUT other code", pend, 5'b00000);
        step(1'b1, 0, 1'b1, 2'b11, '0);
        check_vec("R4 IN other code", pend, 5'b00000);
    endtask

    task automatic t_no_strobe();
        step(1'b0, 2, 1'b1, 2'b01, '0);
        check_vec("R5 IN ACK without last-packet strobe", pend, 5'b00000);
        step(1'b0, 3, 1'b0, 2'b10, '0);
        check_vec("R5 OUT ACK without last-packet strobe", pend, 5'b00000);
    endtask

    task automatic t_bad_index();
        for (int e = 5; e < 8; e++) begin
            step(1'b1, e, 1'b1, 2'b01, '0);
            check_vec("R6 index above 4 IN", pend, 5'b00000);
            step(1'b1, e, 1'b0, 2'b10, '0);
            check_vec("R6 index above 4 OUT", pend, 5'b00000);
        end
    endtask

    task automatic t_hold_clear();
        step(1'b1, 3, 1'b1, 2'b01, '0);
        for (int k = 0; k < 4; k++) step(1'b0, 0, 1'b0, 2'b00, '0);
        check_vec("R7 bit holds without acknowledge", pend, 5'b01000);
        step(1'b0, 0, 1'b0, 2'b00, 5'b01000);
        check_vec("R7 acknowledge clears bit", pend, 5'b00000);
    endtask

    task automatic t_same_cycle();
        step(1'b1, 1, 1'b0, 2'b10, '0);
        step(1'b1, 1, 1'b0, 2'b10, 5'b00010);
        check_vec("R8 event and clear same endpoint", pend, 5'b00010);
        step(1'b1, 4, 1'b1, 2'b01, 5'b00010);
        check_vec("R8 event ep4 while clearing ep1", pend, 5'b10000);
        step(1'b1, 0, 1'b1, 2'b01, 5'b00001);
        check_vec("R8 clear idle bit with its event", pend, 5'b10001);
        clear_all();
    endtask

    task automatic t_enable();
        step(1'b1, 2, 1'b1, 2'b01, '0);
        @(negedge clk); irq_en = 5'b11011;
        #1;
        check_bit("R9 req masked by enable", irq_req, 1'b0);
        check_vec("R9 enable leaves pend", pend, 5'b00100);
        irq_en = 5'b00100;
        #1;
        check_bit("R9 req with enabled pending bit", irq_req, 1'b1);
        irq_en = 5'b11111;
        clear_all();
        check_bit("R9 req drops after clear", irq_req, 1'b0);
    endtask

    task automatic t_clear_isolation();
        step(1'b1, 0, 1'b1, 2'b01, '0);
        step(1'b1, 4, 1'b0, 2'b10, '0);
        step(1'b0, 0, 1'b0, 2'b00, 5'b01110);
        check_vec("R10 clear of idle bits changes nothing", pend, 5'b10001);
        step(1'b0, 0, 1'b0, 2'b00, 5'b10000);
        check_vec("R10 clear touches only its bit", pend, 5'b00001);
        check_vec("R10 model agrees", pend, exp_pend);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_in_ack();
        t_out_ack();
        t_no_ack();
        t_no_strobe();
        t_bad_index();
        t_hold_clear();
        t_same_cycle();
        t_enable();
        t_clear_isolation();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule